// File: doc/BRIEF.md
# Two-Bank Graphics DRAM Command Tracker

This block sits beside the command pins of a two-bank synchronous graphics DRAM and follows, edge by edge, what the memory makes of each command. Every rising clock edge it decodes chip select, row strobe, column strobe, write enable, the special-function pin and clock enable into one command. It then judges that command against the current state of the addressed bank, or of both banks, and updates a per-bank state: idle, row open, plain read or write burst, or read or write burst that closes the row on its own when it ends.

All results are registered. One cycle after the edge that carried a command, the block shows the decoded command, the action it took, an illegal flag and the new bank states. A controller or a bus monitor uses it to catch sequencing errors: an access to a closed bank, a register load while a row is open, a refresh with a row still open, a command during the two-cycle hold after a register load. The end of each burst arrives from outside on a per-bank input, because burst length is not tracked here. The bank bit selects the bank, and the precharge-option bit selects the auto-closing forms of the accesses and the close-all form of precharge.

Top module: `sgram_cmd_tracker`

## Requirements
- R1: With cs_n low, the pins {ras_n,cas_n,we_n,dsf} decode to cmd_o codes as follows: 0110 open row = 2, 0111 open row with per-bit write mask = 3, 1010 read = 4, 1000 write = 5, 1001 block write = 6, 0100 precharge = 7, 1100 burst stop = 8, 1110 or 1111 no-op = 1, 0000 mode load = 11, 0001 special register load = 12, and 0010 refresh = 9 when cke is high or self-refresh entry = 10 when cke is low.
- R2: With cs_n high, cmd_o reports 0 (deselect), action_o is 0, illegal_o stays low and no bank state changes.
- R3: bank_state_o holds 3 bits per bank (bank 0 in bits 2:0), coded idle 0, row open 1, read 2, write 3, read with auto-close 4, write with auto-close 5. All outputs are registered and show the result of a command one cycle after its edge. A synchronous reset returns every bank to idle and every output to 0.
- R4: Opening a row (action 1) is legal only on an idle bank and moves it to row open. Opening on a bank that is not idle is illegal. wpb_o for that bank is set by the masked open and cleared by the plain open.
- R5: Read, write and block write (actions 2, 3, 4) are illegal on an idle bank. On a bank that is row open, reading or writing they start a new burst. The new state is read 2 or write 3 (block write counts as write), or 4 or 5 when ap is high.
- R6: Precharge with ap low closes the addressed bank to idle (action 5); on an already idle bank it is legal and changes nothing. With ap high it closes both banks (action 6).
- R7: Burst stop (action 7) returns every bank in state 2 or 3 to row open. It is illegal when both banks are idle.
- R8: A bank in state 4 or 5 rejects read, write, block write and precharge to that bank; burst stop, and precharge of both banks, are rejected while any bank is in state 4 or 5. Deselect and no-op let the burst continue.
- R9: burst_end[b] high moves bank b from state 2 or 3 to row open and from state 4 or 5 to idle, unless a legal command changes that bank at the same edge.
- R10: Mode load and special register load are legal only with both banks idle (action 12). For the two edges after an accepted one, every command other than deselect or no-op is rejected.
- R11: Refresh (action 8) and self-refresh entry (action 9) are legal only with both banks idle. self_ref_o goes high after entry. While it is high the command pins are ignored and action_o reports 10 as long as cke stays low. The first edge with cke high reports 11, and self_ref_o goes low.
- R12: The undefined codes 0011, 0101, 1011 and 1101 report cmd_o 15. Every rejected command raises illegal_o, reports action_o 15 and leaves the bank states as only burst_end would change them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cke | input | 1 | Clock enable pin of the memory |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| dsf | input | 1 | Special-function pin |
| ba | input | BANK_W (1) | Bank select address bit |
| ap | input | 1 | Precharge-option address bit |
| burst_end | input | NUM_BANKS (2) | Per-bank end-of-burst pulse |
| cmd_o | output | 4 | Decoded command code |
| action_o | output | 4 | Action code taken |
| illegal_o | output | 1 | Command rejected |
| bank_state_o | output | 3*NUM_BANKS (6) | Per-bank state codes |
| wpb_o | output | NUM_BANKS (2) | Per-bank per-bit write mask enabled |
| self_ref_o | output | 1 | Self-refresh in progress |

## Verification
A wrong bank state appears one cycle later as a wrong code on bank_state_o. The next command that depends on it then shows the error a second time, as an illegal flag that should not be there or one that is missing: an auto-close burst left open lets a stray precharge through, and a bank wrongly left open makes the next refresh fail. The register-load hold and the self-refresh state are visible only through the acceptance of the commands that follow, so the sequences place commands at the first and last edge of each window.

// File: rtl/sgram_trk_pkg.sv
package sgram_trk_pkg;

    typedef enum logic [3:0] {
        C_DESEL  = 4'd0,
        C_NOP    = 4'd1,
        C_ACT    = 4'd2,
        C_ACTWPB = 4'd3,
        C_READ   = 4'd4,
        C_WRITE  = 4'd5,
        C_BLKWR  = 4'd6,
        C_PRE    = 4'd7,
        C_TERM   = 4'd8,
        C_REFA   = 4'd9,
        C_REFS   = 4'd10,
        C_MRS    = 4'd11,
        C_SRS    = 4'd12,
        C_UNDEF  = 4'd15
    } cmd_e;

    typedef enum logic [2:0] {
        B_IDLE   = 3'd0,
        B_ACTIVE = 3'd1,
        B_RD     = 3'd2,
        B_WR     = 3'd3,
        B_RDA    = 3'd4,
        B_WRA    = 3'd5
    } bank_e;

    typedef enum logic [3:0] {
        A_NONE      = 4'd0,
        A_OPEN      = 4'd1,
        A_READ      = 4'd2,
        A_WRITE     = 4'd3,
        A_BLOCK     = 4'd4,
        A_PRE       = 4'd5,
        A_PRE_ALL   = 4'd6,
        A_TERM      = 4'd7,
        A_REFRESH   = 4'd8,
        A_SREF_IN   = 4'd9,
        A_SREF_STAY = 4'd10,
        A_SREF_OUT  = 4'd11,
        A_REG_SET   = 4'd12,
        A_REJECT    = 4'd15
    } act_e;

endpackage

// File: rtl/sgram_cmd_decode.sv
module sgram_cmd_decode
    import sgram_trk_pkg::*;
(
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    input  logic dsf,
    input  logic cke,
    output cmd_e cmd
);
    always_comb begin
        if (cs_n) begin
            cmd = C_DESEL;
        end else begin
            case ({ras_n, cas_n, we_n, dsf})
                4'b0110: cmd = C_ACT;
                4'b0111: cmd = C_ACTWPB;
                4'b1010: cmd = C_READ;
                4'b1000: cmd = C_WRITE;
                4'b1001: cmd = C_BLKWR;
                4'b0100: cmd = C_PRE;
                4'b1100: cmd = C_TERM;
                4'b1110: cmd = C_NOP;
                4'b1111: cmd = C_NOP;
                4'b0010: cmd = cke ? C_REFA : C_REFS;
                4'b0000: cmd = C_MRS;
                4'b0001: cmd = C_SRS;
                default: cmd = C_UNDEF;
            endcase
        end
    end
endmodule

// File: rtl/sgram_bank_fsm.sv
module sgram_bank_fsm
    import sgram_trk_pkg::*;
(
    input  bank_e st,
    input  logic  sel,
    input  cmd_e  cmd,
    input  logic  ap,
    input  logic  ok,
    input  logic  burst_end,
    output bank_e st_next
);
    logic hit;

    always_comb begin
        st_next = st;
        hit     = 1'b0;
        if (ok) begin
            case (cmd)
                C_ACT, C_ACTWPB: if (sel) begin
                    st_next = B_ACTIVE;
                    hit     = 1'b1;
                end
                C_READ: if (sel) begin
                    st_next = ap ? B_RDA : B_RD;
                    hit     = 1'b1;
                end
                C_WRITE, C_BLKWR: if (sel) begin
                    st_next = ap ? B_WRA : B_WR;
                    hit     = 1'b1;
                end
                C_PRE: if (sel || ap) begin
                    st_next = B_IDLE;
                    hit     = 1'b1;
                end
                C_TERM: if (st == B_RD || st == B_WR) begin
                    st_next = B_ACTIVE;
                    hit     = 1'b1;
                end
                default: ;
            endcase
        end
        if (!hit && burst_end) begin
            case (st)
                B_RD, B_WR:   st_next = B_ACTIVE;
                B_RDA, B_WRA: st_next = B_IDLE;
                default:      ;
            endcase
        end
    end
endmodule

// File: rtl/sgram_cmd_tracker.sv
module sgram_cmd_tracker
    import sgram_trk_pkg::*;
#(
    parameter int NUM_BANKS = 2,
    parameter int BLACKOUT  = 2,
    localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    localparam int ST_W     = 3
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      cke,
    input  logic                      cs_n,
    input  logic                      ras_n,
    input  logic                      cas_n,
    input  logic                      we_n,
    input  logic                      dsf,
    input  logic [BANK_W-1:0]         ba,
    input  logic                      ap,
    input  logic [NUM_BANKS-1:0]      burst_end,
    output logic [3:0]                cmd_o,
    output logic [3:0]                action_o,
    output logic                      illegal_o,
    output logic [NUM_BANKS*ST_W-1:0] bank_state_o,
    output logic [NUM_BANKS-1:0]      wpb_o,
    output logic                      self_ref_o
);
    localparam int CNT_W = $clog2(BLACKOUT + 1);

    typedef struct packed {
        cmd_e                    cmd;
        act_e                    act;
        logic                    ill;
        logic                    sref;
        logic [CNT_W-1:0]        blk;
        logic [NUM_BANKS-1:0]    wpb;
        bank_e [NUM_BANKS-1:0]   st;
    } trk_s;

    typedef struct packed {
        logic                    ok;
        act_e                    act;
        logic                    ill;
        logic                    sref;
        logic [CNT_W-1:0]        blk;
        logic [NUM_BANKS-1:0]    wpb;
    } ctl_s;

    trk_s  r_q, r_d;
    ctl_s  ctl_d;
    cmd_e  cmd;
    bank_e tgt;
    bank_e nxt [NUM_BANKS];
    logic  all_idle, any_ap, quiet;

    sgram_cmd_decode u_dec (
        .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .dsf(dsf), .cke(cke), .cmd(cmd)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        sgram_bank_fsm u_fsm (
            .st(r_q.st[b]),
            .sel(ba == BANK_W'(b)),
            .cmd(cmd),
            .ap(ap),
            .ok(ctl_d.ok),
            .burst_end(burst_end[b]),
            .st_next(nxt[b])
        );
        assign bank_state_o[b*ST_W +: ST_W] = r_q.st[b];
    end

    always_comb begin
        all_idle = 1'b1;
        any_ap   = 1'b0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (r_q.st[b] != B_IDLE) all_idle = 1'b0;
            if (r_q.st[b] == B_RDA || r_q.st[b] == B_WRA) any_ap = 1'b1;
        end
    end

    assign tgt   = r_q.st[ba];
    assign quiet = (cmd == C_DESEL) || (cmd == C_NOP);

    // Legality and side effects of the command at this edge
    always_comb begin
        ctl_d.ok   = 1'b0;
        ctl_d.act  = A_NONE;
        ctl_d.ill  = 1'b0;
        ctl_d.sref = r_q.sref;
        ctl_d.blk  = r_q.blk;
        ctl_d.wpb  = r_q.wpb;
        if (r_q.sref) begin
            ctl_d.act = cke ? A_SREF_OUT : A_SREF_STAY;
            if (cke) ctl_d.sref = 1'b0;
        end else if (r_q.blk != '0) begin
            ctl_d.blk = r_q.blk - 1'b1;
            if (!quiet) begin
                ctl_d.ill = 1'b1;
                ctl_d.act = A_REJECT;
            end
        end else begin
            case (cmd)
                C_ACT, C_ACTWPB: begin
                    ctl_d.ok  = (tgt == B_IDLE);
                    ctl_d.act = A_OPEN;
                    if (ctl_d.ok) ctl_d.wpb[ba] = (cmd == C_ACTWPB);
                end
                C_READ, C_WRITE, C_BLKWR: begin
                    ctl_d.ok  = (tgt == B_ACTIVE) || (tgt == B_RD) || (tgt == B_WR);
                    ctl_d.act = (cmd == C_READ)  ? A_READ :
                                (cmd == C_WRITE) ? A_WRITE : A_BLOCK;
                end
                C_PRE: begin
                    ctl_d.ok  = ap ? !any_ap : !(tgt == B_RDA || tgt == B_WRA);
                    ctl_d.act = ap ? A_PRE_ALL : A_PRE;
                end
                C_TERM: begin
                    ctl_d.ok  = !any_ap && !all_idle;
                    ctl_d.act = A_TERM;
                end
                C_REFA: begin
                    ctl_d.ok  = all_idle;
                    ctl_d.act = A_REFRESH;
                end
                C_REFS: begin
                    ctl_d.ok   = all_idle;
                    ctl_d.act  = A_SREF_IN;
                    ctl_d.sref = all_idle;
                end
                C_MRS, C_SRS: begin
                    ctl_d.ok  = all_idle;
                    ctl_d.act = A_REG_SET;
                    if (all_idle) ctl_d.blk = CNT_W'(BLACKOUT);
                end
                default: ctl_d.ok = 1'b0;
            endcase
            if (!ctl_d.ok && !quiet) begin
                ctl_d.ill = 1'b1;
                ctl_d.act = A_REJECT;
            end
        end
    end

    always_comb begin
        r_d.cmd  = cmd;
        r_d.act  = ctl_d.act;
        r_d.ill  = ctl_d.ill;
        r_d.sref = ctl_d.sref;
        r_d.blk  = ctl_d.blk;
        r_d.wpb  = ctl_d.wpb;
        for (int b = 0; b < NUM_BANKS; b++) r_d.st[b] = nxt[b];
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '0;
        else     r_q <= r_d;
    end

    assign cmd_o      = r_q.cmd;
    assign action_o   = r_q.act;
    assign illegal_o  = r_q.ill;
    assign wpb_o      = r_q.wpb;
    assign self_ref_o = r_q.sref;

endmodule

// File: rtl/sgram_cmd_tracker_chk.sv
module sgram_cmd_tracker_chk #(
    parameter int NUM_BANKS = 2
) (
    input logic                   clk,
    input logic                   rst,
    input logic [NUM_BANKS-1:0]   burst_end,
    input logic [3:0]             cmd_o,
    input logic [3:0]             action_o,
    input logic                   illegal_o,
    input logic [NUM_BANKS*3-1:0] bank_state_o,
    input logic                   self_ref_o
);
    // R3: reset clears states, flag and self-refresh
    a_r3_reset_idle: assert property (@(posedge clk)
        rst |=> (bank_state_o == '0 && !illegal_o && !self_ref_o));

    // R10: the edge after an accepted register load admits only quiet commands
    a_r10_blackout: assert property (@(posedge clk) disable iff (rst)
        (action_o == 4'd12 && !illegal_o) |=> (cmd_o <= 4'd1 || illegal_o));

    // R11: banks stay idle throughout self-refresh
    a_r11_sref_idle: assert property (@(posedge clk) disable iff (rst)
        self_ref_o |-> bank_state_o == '0);

    // R12: a rejected command leaves states unchanged when no burst ended
    a_r12_reject_holds: assert property (@(posedge clk) disable iff (rst)
        (illegal_o && $past(burst_end) == '0) |-> bank_state_o == $past(bank_state_o));

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_ap
        // R8: an auto-closing burst only stays or closes to idle
        a_r8_ap_closes: assert property (@(posedge clk) disable iff (rst)
            (bank_state_o[b*3 +: 3] == 3'd4 || bank_state_o[b*3 +: 3] == 3'd5)
            |=> (bank_state_o[b*3 +: 3] == $past(bank_state_o[b*3 +: 3])
                 || bank_state_o[b*3 +: 3] == 3'd0));
    end
endmodule

bind sgram_cmd_tracker sgram_cmd_tracker_chk #(.NUM_BANKS(NUM_BANKS)) u_chk (
    .clk(clk), .rst(rst), .burst_end(burst_end), .cmd_o(cmd_o),
    .action_o(action_o), .illegal_o(illegal_o),
    .bank_state_o(bank_state_o), .self_ref_o(self_ref_o)
);

// File: tb/sgram_cmd_tracker_test.sv
module sgram_cmd_tracker_test;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 33;

    // pin codes {ras_n,cas_n,we_n,dsf}
    localparam logic [3:0] P_ACT = 4'b0110, P_AWP = 4'b0111, P_RD = 4'b1010,
                           P_WR = 4'b1000, P_BW = 4'b1001, P_PRE = 4'b0100,
                           P_TRM = 4'b1100, P_NOP = 4'b1110, P_REF = 4'b0010,
                           P_MRS = 4'b0000, P_SRS = 4'b0001, P_UND = 4'b0011;

    // {req, cke, cs_n, pins, ba, ap, burst_end, exp cmd, exp action, exp ill, exp st0, exp st1}
    localparam logic [28:0] VEC [NV] = '{
        {4'd1,  1'b1,1'b0,P_NOP,1'b0,1'b0,2'b00, 4'd1, 4'd0, 1'b0,3'd0,3'd0}, // R1
        {4'd5,  1'b1,1'b0,P_RD, 1'b0,1'b0,2'b00, 4'd4, 4'd15,1'b1,3'd0,3'd0}, // R5 idle read
        {4'd4,  1'b1,1'b0,P_ACT,1'b0,1'b0,2'b00, 4'd2, 4'd1, 1'b0,3'd1,3'd0}, // R4
        {4'd4,  1'b1,1'b0,P_AWP,1'b1,1'b0,2'b00, 4'd3, 4'd1, 1'b0,3'd1,3'd1}, // R4
        {4'd5,  1'b1,1'b0,P_RD, 1'b0,1'b0,2'b00, 4'd4, 4'd2, 1'b0,3'd2,3'd1}, // R5
        {4'd5,  1'b1,1'b0,P_WR, 1'b0,1'b0,2'b00, 4'd5, 4'd3, 1'b0,3'd3,3'd1}, // R5 interrupt
        {4'd7,  1'b1,1'b0,P_TRM,1'b0,1'b0,2'b00, 4'd8, 4'd7, 1'b0,3'd1,3'd1}, // R7
        {4'd5,  1'b1,1'b0,P_BW, 1'b1,1'b1,2'b00, 4'd6, 4'd4, 1'b0,3'd1,3'd5}, // R5 block ap
        {4'd8,  1'b1,1'b0,P_PRE,1'b1,1'b0,2'b00, 4'd7, 4'd15,1'b1,3'd1,3'd5}, // R8
        {4'd9,  1'b1,1'b0,P_NOP,1'b0,1'b0,2'b10, 4'd1, 4'd0, 1'b0,3'd1,3'd0}, // R9
        {4'd10, 1'b1,1'b0,P_MRS,1'b0,1'b0,2'b00, 4'd11,4'd15,1'b1,3'd1,3'd0}, // R10 not idle
        {4'd5,  1'b1,1'b0,P_RD, 1'b0,1'b1,2'b00, 4'd4, 4'd2, 1'b0,3'd4,3'd0}, // R5 read ap
        {4'd8,  1'b1,1'b0,P_TRM,1'b0,1'b0,2'b00, 4'd8, 4'd15,1'b1,3'd4,3'd0}, // R8
        {4'd9,  1'b1,1'b0,P_NOP,1'b0,1'b0,2'b01, 4'd1, 4'd0, 1'b0,3'd0,3'd0}, // R9
        {4'd10, 1'b1,1'b0,P_SRS,1'b0,1'b0,2'b00, 4'd12,4'd12,1'b0,3'd0,3'd0}, // R10
        {4'd10, 1'b1,1'b0,P_ACT,1'b0,1'b0,2'b00, 4'd2, 4'd15,1'b1,3'd0,3'd0}, // R10 hold 1
        {4'd10, 1'b1,1'b0,P_NOP,1'b0,1'b0,2'b00, 4'd1, 4'd0, 1'b0,3'd0,3'd0}, // R10 hold 2
        {4'd4,  1'b1,1'b0,P_ACT,1'b1,1'b0,2'b00, 4'd2, 4'd1, 1'b0,3'd0,3'd1}, // R4 after hold
        {4'd6,  1'b1,1'b0,P_PRE,1'b0,1'b1,2'b00, 4'd7, 4'd6, 1'b0,3'd0,3'd0}, // R6 all
        {4'd11, 1'b1,1'b0,P_REF,1'b0,1'b0,2'b00, 4'd9, 4'd8, 1'b0,3'd0,3'd0}, // R11
        {4'd12, 1'b1,1'b0,P_UND,1'b0,1'b0,2'b00, 4'd15,4'd15,1'b1,3'd0,3'd0}, // R12
        {4'd2,  1'b1,1'b1,P_ACT,1'b0,1'b0,2'b00, 4'd0, 4'd0, 1'b0,3'd0,3'd0}, // R2
        {4'd11, 1'b0,1'b0,P_REF,1'b0,1'b0,2'b00, 4'd10,4'd9, 1'b0,3'd0,3'd0}, // R11 enter
        {4'd11, 1'b0,1'b0,P_ACT,1'b0,1'b0,2'b00, 4'd2, 4'd10,1'b0,3'd0,3'd0}, // R11 stay
        {4'd11, 1'b1,1'b0,P_NOP,1'b0,1'b0,2'b00, 4'd1, 4'd11,1'b0,3'd0,3'd0}, // R11 exit
        {4'd4,  1'b1,1'b0,P_ACT,1'b0,1'b0,2'b00, 4'd2, 4'd1, 1'b0,3'd1,3'd0}, // R4
        {4'd5,  1'b1,1'b0,P_RD, 1'b0,1'b0,2'b00, 4'd4, 4'd2, 1'b0,3'd2,3'd0}, // R5
        {4'd9,  1'b1,1'b0,P_NOP,1'b0,1'b0,2'b01, 4'd1, 4'd0, 1'b0,3'd1,3'd0}, // R9
        {4'd6,  1'b1,1'b0,P_PRE,1'b0,1'b0,2'b00, 4'd7, 4'd5, 1'b0,3'd0,3'd0}, // R6
        {4'd6,  1'b1,1'b0,P_PRE,1'b0,1'b0,2'b00, 4'd7, 4'd5, 1'b0,3'd0,3'd0}, // R6 idle
        {4'd4,  1'b1,1'b0,P_ACT,1'b0,1'b0,2'b00, 4'd2, 4'd1, 1'b0,3'd1,3'd0}, // R4
        {4'd11, 1'b1,1'b0,P_REF,1'b0,1'b0,2'b00, 4'd9, 4'd15,1'b1,3'd1,3'd0}, // R11 open row
        {4'd4,  1'b1,1'b0,P_ACT,1'b0,1'b0,2'b00, 4'd2, 4'd15,1'b1,3'd1,3'd0}  // R4 reopen
    };

    logic clk = 1'b0, rst = 1'b1;
    logic cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, dsf = 1'b0;
    logic [0:0] ba = '0;
    logic ap = 1'b0;
    logic [1:0] burst_end = '0;
    logic [3:0] cmd_o, action_o;
    logic illegal_o, self_ref_o;
    logic [5:0] bank_state_o;
    logic [1:0] wpb_o;
    int checks = 0, fails = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sgram_cmd_tracker uut (
        .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .dsf(dsf), .ba(ba), .ap(ap),
        .burst_end(burst_end), .cmd_o(cmd_o), .action_o(action_o),
        .illegal_o(illegal_o), .bank_state_o(bank_state_o),
        .wpb_o(wpb_o), .self_ref_o(self_ref_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input logic k, input logic cs, input logic [3:0] p,
                         input logic b, input logic a, input logic [1:0] be);
        cke = k; cs_n = cs; {ras_n, cas_n, we_n, dsf} = p; ba = b; ap = a; burst_end = be;
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        if (!finished) begin
            fails++;
            $display("FAIL R3: watchdog actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R3: reset state
        check("R3", {17'd0, cmd_o, action_o, illegal_o, bank_state_o, wpb_o, self_ref_o}, 32'd0);
        rst = 1'b0;
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][24], VEC[i][23], VEC[i][22:19], VEC[i][18], VEC[i][17], VEC[i][16:15]);
            check($sformatf("R%0d vec%0d", VEC[i][28:25], i),
                  {17'd0, cmd_o, action_o, illegal_o, bank_state_o[2:0], bank_state_o[5:3]},
                  {17'd0, VEC[i][14:0]});
        end
        // R4: masked open sets the per-bit mask of bank 0 only
        drive(1'b1, 1'b0, P_PRE, 1'b0, 1'b0, 2'b00);
        drive(1'b1, 1'b0, P_AWP, 1'b0, 1'b0, 2'b00);
        check("R4 wpb", {30'd0, wpb_o}, 32'd1);
        // R10: mode load hold rejects precharge at both edges, then accepts
        drive(1'b1, 1'b0, P_PRE, 1'b0, 1'b1, 2'b00);
        drive(1'b1, 1'b0, P_MRS, 1'b0, 1'b0, 2'b00);
        check("R10 mrs", {28'd0, action_o}, 32'd12);
        drive(1'b1, 1'b0, P_PRE, 1'b0, 1'b0, 2'b00);
        check("R10 hold1", {31'd0, illegal_o}, 32'd1);
        drive(1'b1, 1'b0, P_PRE, 1'b0, 1'b0, 2'b00);
        check("R10 hold2", {31'd0, illegal_o}, 32'd1);
        drive(1'b1, 1'b0, P_PRE, 1'b0, 1'b0, 2'b00);
        check("R10 after", {27'd0, illegal_o, action_o}, 32'd5);
        // R11: self_ref_o follows entry and exit
        drive(1'b0, 1'b0, P_REF, 1'b0, 1'b0, 2'b00);
        check("R11 sref on", {31'd0, self_ref_o}, 32'd1);
        drive(1'b0, 1'b1, P_NOP, 1'b0, 1'b0, 2'b00);
        check("R11 sref hold", {31'd0, self_ref_o}, 32'd1);
        drive(1'b1, 1'b1, P_NOP, 1'b0, 1'b0, 2'b00);
        check("R11 sref off", {31'd0, self_ref_o}, 32'd0);
        // R3: reset in the middle of an open row
        drive(1'b1, 1'b0, P_ACT, 1'b1, 1'b0, 2'b00);
        check("R3 open", {26'd0, bank_state_o}, 32'h08);
        rst = 1'b1;
        drive(1'b1, 1'b0, P_ACT, 1'b0, 1'b0, 2'b00);
        check("R3 mid reset", {17'd0, cmd_o, action_o, illegal_o, bank_state_o, wpb_o, self_ref_o}, 32'd0);
        rst = 1'b0;
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule